// File: doc/BRIEF.md
# Aligned DMA Burst Segmenter

This block cuts one DMA transfer between a device address space and system memory into bus bursts that never cross a 128-byte memory block. Software programs a memory address, a device address and a byte length through a small register write port; a write of the length starts the transfer. The block folds the starting byte offset of the memory address within its 8-byte double-word into the length. It then works out how many double-words the next burst may carry, raises a bus request, and waits for a grant. While the burst runs it counts data beats, and when the burst ends it steps the memory address to the next block.

The controller is a state machine with seven states. S_IDLE accepts register writes. S_KICK folds in the offset and turns the length into a double-word count. S_SIZE computes the burst size. S_REQ drives the request. S_XFER counts beats. S_DRAIN holds the burst busy for three clocks after the last beat. S_FIN pulses done. The transitions are:
- S_IDLE to S_KICK on a start write.
- S_KICK to S_FIN for a zero length, otherwise S_KICK to S_SIZE.
- S_SIZE to S_REQ.
- S_REQ to S_XFER on grant.
- S_XFER to S_DRAIN on the last beat.
- S_DRAIN to S_SIZE if double-words remain, otherwise S_DRAIN to S_FIN.
- S_FIN to S_IDLE.
- Any state from S_KICK through S_DRAIN to S_IDLE on stop.

Top module: `dma_burst_segmenter`

## Requirements
- R1: A write with reg_sel = 0 while idle loads mem_addr from reg_wdata with bit 0 forced to zero.
- R2: A write with reg_sel = 2 while idle starts a transfer: busy rises on the next clock. One clock later, remain_dw becomes ceil((length + mem_addr[2:0]) / 8), where length is reg_wdata[23:0].
- R3: Each burst size burst_dw is the smaller of remain_dw and 16 - mem_addr[6:3]. The first burst therefore ends on a 128-byte boundary, and later bursts carry 16 double-words or the remainder.
- R4: On the clock that takes the last beat of a burst (bus_beat and bus_last in S_XFER), mem_addr becomes the start of the next 128-byte block.
- R5: Each bus_beat in S_XFER lowers remain_dw by one and adds 8 to dev_addr. A write with reg_sel = 1 while idle loads dev_addr unchanged.
- R6: A zero length raises no bus_req and still produces a done pulse.
- R7: A write with reg_sel = 3 starts nothing and pulses err_irq on the next clock.
- R8: Writes with reg_sel 0, 1 or 2 while busy leave mem_addr, dev_addr and the transfer unchanged.
- R9: burst_busy stays high for exactly three clocks after the last beat of a burst. stop in any busy state other than S_FIN returns the block to idle on the next clock, without done.
- R10: bus_req stays high until bus_grant or stop, and rises once per burst.
- R11: done is a one-clock pulse, given once after the final burst has drained with remain_dw at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_sel | input | 2 | 0 memory address, 1 device address, 2 length and start, 3 read-direction length |
| reg_wdata | input | 32 | register write data |
| stop | input | 1 | abort the transfer |
| bus_grant | input | 1 | grant for the pending request |
| bus_beat | input | 1 | one double-word moved |
| bus_last | input | 1 | marks the final beat of a burst |
| bus_req | output | 1 | burst request |
| burst_dw | output | 5 | double-words in the current burst |
| mem_addr | output | 32 | current memory address |
| dev_addr | output | 32 | current device address |
| remain_dw | output | 22 | double-words still to move |
| busy | output | 1 | transfer in progress |
| burst_busy | output | 1 | burst requested, running or draining |
| done | output | 1 | completion pulse |
| err_irq | output | 1 | read-direction start attempted |

## Verification
The hardest cases to reach are the boundary ones. One is a start address in the last double-word of a block with a nonzero byte offset, where the first burst is a single double-word and the offset pushes the count up by one. The other is a stop that lands while the request is pending or part-way through a burst. The bench reaches them with directed transfers. A bus agent in the bench answers each request after a chosen grant delay and beat spacing. It can also inject a stop in place of the grant or after the first beat, and it can write the registers while beats are flowing. A behavioural reference model is compared against every output on every clock.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_KICK,
        S_SIZE,
        S_REQ,
        S_XFER,
        S_DRAIN,
        S_FIN
    } seg_state_t;

    localparam logic [1:0] SEL_MEM  = 2'd0;
    localparam logic [1:0] SEL_DEV  = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;
    localparam logic [1:0] SEL_RLEN = 2'd3;
endpackage

// File: rtl/dseg_fsm.sv
module dseg_fsm
    import dseg_pkg::*;
#(
    parameter int DRAIN_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       len_zero,
    input  logic       rem_zero,
    input  logic       grant,
    input  logic       last_ok,
    input  logic       stop,
    output seg_state_t st,
    output logic       bus_req,
    output logic       busy,
    output logic       burst_busy,
    output logic       done
);
    localparam int DC_W = $clog2(DRAIN_CYC + 1);

    seg_state_t nxt;
    logic [DC_W-1:0] dcnt;

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (start) nxt = S_KICK;
            S_KICK:  nxt = len_zero ? S_FIN : S_SIZE;
            S_SIZE:  nxt = S_REQ;
            S_REQ:   if (grant) nxt = S_XFER;
            S_XFER:  if (last_ok) nxt = S_DRAIN;
            S_DRAIN: if (dcnt == DC_W'(DRAIN_CYC - 1)) nxt = rem_zero ? S_FIN : S_SIZE;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (stop && st != S_IDLE && st != S_FIN) nxt = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            dcnt <= '0;
        end else begin
            st   <= nxt;
            dcnt <= (st == S_DRAIN) ? dcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        bus_req    = (st == S_REQ);
        busy       = (st != S_IDLE);
        burst_busy = (st == S_REQ) || (st == S_XFER) || (st == S_DRAIN);
        done       = (st == S_FIN);
    end

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !grant && !stop |=> bus_req);
    p_req_to_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && grant && !stop |=> !bus_req && burst_busy);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop && busy && !done |=> !busy && !done);
    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last_ok && !stop |=> burst_busy && !bus_req);
endmodule

// File: rtl/dseg_len.sv
module dseg_len
    import dseg_pkg::*;
#(
    parameter int LEN_W   = 24,
    parameter int BLK_LG2 = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  seg_state_t             st,
    input  logic                   load_len,
    input  logic [LEN_W-1:0]       wdata,
    input  logic [2:0]             mem_off,
    input  logic [BLK_LG2-4:0]     mem_blk_idx,
    input  logic                   beat_ok,
    output logic                   len_zero,
    output logic                   rem_zero,
    output logic [LEN_W-3:0]       rem_dw,
    output logic [BLK_LG2-3:0]     burst_dw
);
    localparam int REM_W  = LEN_W - 2;
    localparam int BW     = BLK_LG2 - 2;
    localparam int BLK_DW = 2 ** (BLK_LG2 - 3);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   len_sum;
    logic [BW-1:0]    room;

    assign len_zero = (len_q == '0);
    assign rem_zero = (rem_dw == '0);
    assign len_sum  = {1'b0, len_q} + (LEN_W+1)'(mem_off) + (LEN_W+1)'(7);
    assign room     = BW'(BLK_DW) - BW'(mem_blk_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            rem_dw   <= '0;
            burst_dw <= '0;
        end else begin
            if (load_len) len_q <= wdata;
            if (st == S_KICK)
                rem_dw <= len_zero ? '0 : len_sum[LEN_W:3];
            else if (beat_ok && !rem_zero)
                rem_dw <= rem_dw - 1'b1;
            if (st == S_SIZE)
                burst_dw <= (rem_dw < REM_W'(room)) ? BW'(rem_dw) : room;
        end
    end

    p_rem_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ok && !rem_zero && st == S_XFER |=> rem_dw == $past(rem_dw) - 1'b1);
    p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_REQ |-> burst_dw != '0 && burst_dw <= BW'(BLK_DW));
endmodule

// File: rtl/dseg_addr.sv
module dseg_addr
    import dseg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_LG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              beat_ok,
    input  logic              last_ok,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] dev_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dev_addr <= '0;
        end else begin
            if (idle && we && sel == SEL_MEM)
                mem_addr <= {wdata[ADDR_W-1:1], 1'b0};
            else if (last_ok)
                mem_addr <= {mem_addr[ADDR_W-1:BLK_LG2] + 1'b1, {BLK_LG2{1'b0}}};

            if (idle && we && sel == SEL_DEV)
                dev_addr <= wdata;
            else if (beat_ok)
                dev_addr <= {dev_addr[ADDR_W-1:3] + 1'b1, dev_addr[2:0]};
        end
    end

    p_mem_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_addr[0]);
    p_realign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last_ok |=> mem_addr[BLK_LG2-1:0] == '0);
    p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle && !beat_ok && !last_ok |=> $stable(mem_addr) && $stable(dev_addr));
endmodule

// File: rtl/dma_burst_segmenter.sv
module dma_burst_segmenter
    import dseg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 24,
    parameter int BLK_LG2   = 7,
    parameter int DRAIN_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [ADDR_W-1:0]    reg_wdata,
    input  logic                 stop,
    input  logic                 bus_grant,
    input  logic                 bus_beat,
    input  logic                 bus_last,
    output logic                 bus_req,
    output logic [BLK_LG2-3:0]   burst_dw,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [ADDR_W-1:0]    dev_addr,
    output logic [LEN_W-3:0]     remain_dw,
    output logic                 busy,
    output logic                 burst_busy,
    output logic                 done,
    output logic                 err_irq
);
    seg_state_t st;
    logic idle, start, beat_ok, last_ok, len_zero, rem_zero;

    assign idle    = (st == S_IDLE);
    assign start   = idle && reg_we && reg_sel == SEL_LEN;
    assign beat_ok = (st == S_XFER) && bus_beat;
    assign last_ok = beat_ok && bus_last;

    always_ff @(posedge clk) begin
        if (!rst_n) err_irq <= 1'b0;
        else        err_irq <= reg_we && reg_sel == SEL_RLEN;
    end

    dseg_fsm #(.DRAIN_CYC(DRAIN_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .len_zero(len_zero),
        .rem_zero(rem_zero), .grant(bus_grant), .last_ok(last_ok), .stop(stop),
        .st(st), .bus_req(bus_req), .busy(busy), .burst_busy(burst_busy),
        .done(done)
    );

    dseg_len #(.LEN_W(LEN_W), .BLK_LG2(BLK_LG2)) u_len (
        .clk(clk), .rst_n(rst_n), .st(st), .load_len(start),
        .wdata(reg_wdata[LEN_W-1:0]), .mem_off(mem_addr[2:0]),
        .mem_blk_idx(mem_addr[BLK_LG2-1:3]), .beat_ok(beat_ok),
        .len_zero(len_zero), .rem_zero(rem_zero), .rem_dw(remain_dw),
        .burst_dw(burst_dw)
    );

    dseg_addr #(.ADDR_W(ADDR_W), .BLK_LG2(BLK_LG2)) u_addr (
        .clk(clk), .rst_n(rst_n), .idle(idle), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .beat_ok(beat_ok), .last_ok(last_ok),
        .mem_addr(mem_addr), .dev_addr(dev_addr)
    );

    p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(reg_we) && $past(reg_sel) == SEL_RLEN);
    p_no_rlen_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idle && reg_we && reg_sel == SEL_RLEN |=> !busy);
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_KICK && len_zero |=> done && !bus_req);
endmodule

// File: tb/dma_burst_segmenter_test.sv
`timescale 1ns/1ps
module dma_burst_segmenter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic stop = 1'b0, bus_grant = 1'b0, bus_beat = 1'b0, bus_last = 1'b0;
    logic bus_req, busy, burst_busy, done, err_irq;
    logic [4:0] burst_dw;
    logic [31:0] mem_addr, dev_addr;
    logic [21:0] remain_dw;

    int checks = 0, errors = 0;
    int req_rises = 0, done_cnt = 0, err_cnt = 0;
    logic prev_req = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_burst_segmenter uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stop(stop), .bus_grant(bus_grant),
        .bus_beat(bus_beat), .bus_last(bus_last), .bus_req(bus_req),
        .burst_dw(burst_dw), .mem_addr(mem_addr), .dev_addr(dev_addr),
        .remain_dw(remain_dw), .busy(busy), .burst_busy(burst_busy),
        .done(done), .err_irq(err_irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: phase 0 idle,1 kick,2 size,3 request,4 beats,5 drain,6 finish
    logic [31:0] m_mem = '0, m_dev = '0;
    int m_len = 0, m_rem = 0, m_bdw = 0, m_ph = 0, m_dc = 0;
    bit m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mem = '0; m_dev = '0; m_len = 0; m_rem = 0; m_bdw = 0; m_ph = 0; m_dc = 0; m_err = 0;
        end else begin
            m_err = reg_we && reg_sel == 2'd3;
            if (m_ph == 0) begin
                if (reg_we && reg_sel == 2'd0) m_mem = reg_wdata & ~32'd1;
                if (reg_we && reg_sel == 2'd1) m_dev = reg_wdata;
                if (reg_we && reg_sel == 2'd2) begin m_len = int'(reg_wdata[23:0]); m_ph = 1; end
            end else begin
                if (m_ph == 4 && bus_beat) begin
                    if (m_rem > 0) m_rem--;
                    m_dev = m_dev + 32'd8;
                    if (bus_last) m_mem = (m_mem | 32'd127) + 32'd1;
                end
                if (stop && m_ph != 6) m_ph = 0;
                else case (m_ph)
                    1: if (m_len == 0) begin m_rem = 0; m_ph = 6; end
                       else begin m_rem = (m_len + int'(m_mem & 32'd7) + 7) / 8; m_ph = 2; end
                    2: begin
                        int room;
                        room = 16 - int'((m_mem >> 3) & 32'd15);
                        m_bdw = (m_rem < room) ? m_rem : room;
                        m_ph = 3;
                    end
                    3: if (bus_grant) m_ph = 4;
                    4: if (bus_beat && bus_last) begin m_ph = 5; m_dc = 0; end
                    5: if (m_dc == 2) m_ph = (m_rem == 0) ? 6 : 2; else m_dc++;
                    6: m_ph = 0;
                    default: m_ph = 0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_req === (m_ph == 3), "R10 bus_req", bus_req, m_ph == 3);
            chk(busy === (m_ph != 0), "R2 busy", busy, m_ph != 0);
            chk(burst_busy === (m_ph >= 3 && m_ph <= 5), "R9 burst_busy", burst_busy, m_ph >= 3 && m_ph <= 5);
            chk(done === (m_ph == 6), "R11 done", done, m_ph == 6);
            chk(err_irq === m_err, "R7 err_irq", err_irq, m_err);
            chk(mem_addr === m_mem, "R4 mem_addr", mem_addr, m_mem);
            chk(dev_addr === m_dev, "R5 dev_addr", dev_addr, m_dev);
            chk(int'(remain_dw) == m_rem, "R2 remain_dw", remain_dw, m_rem);
            if (m_ph == 3 || m_ph == 4)
                chk(int'(burst_dw) == m_bdw, "R3 burst_dw", burst_dw, m_bdw);
            if (bus_req && !prev_req) req_rises++;
            if (done) done_cnt++;
            if (err_irq) err_cnt++;
            prev_req = bus_req;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clr_counts();
        req_rises = 0; done_cnt = 0; err_cnt = 0;
    endtask

    // smode: 0 normal, 1 stop instead of first grant, 2 stop after first beat
    task automatic serve(input int gapg, input int gapb, input int smode, input bit conflict);
        int guard = 0;
        while (busy && guard < 5000) begin
            guard++;
            if (bus_req) begin
                repeat (gapg) @(negedge clk);
                if (smode == 1) begin
                    stop = 1'b1; @(negedge clk); stop = 1'b0;
                end else begin
                    int n;
                    bus_grant = 1'b1; @(negedge clk); bus_grant = 1'b0;
                    n = int'(burst_dw);
                    for (int i = 0; i < n; i++) begin
                        repeat (gapb) @(negedge clk);
                        bus_beat = 1'b1; bus_last = (i == n - 1);
                        if (conflict) begin
                            reg_we = 1'b1; reg_sel = 2'(i % 3); reg_wdata = 32'h0000_0100;
                        end
                        @(negedge clk);
                        bus_beat = 1'b0; bus_last = 1'b0; reg_we = 1'b0;
                        if (smode == 2) begin
                            stop = 1'b1; @(negedge clk); stop = 1'b0;
                            break;
                        end
                    end
                end
            end else @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !busy && !done && !err_irq && mem_addr == 0 && remain_dw == 0,
            "R2 reset state", {bus_req, busy, done, err_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: odd address loses bit 0; R3: first burst ends at block boundary
        wr(2'd0, 32'h1000_0035);
        chk(mem_addr == 32'h1000_0034, "R1 mem bit0 cleared", mem_addr, 32'h1000_0034);
        wr(2'd1, 32'h2000_0005);
        clr_counts();
        wr(2'd2, 32'd1000);
        serve(1, 0, 0, 0);
        chk(done_cnt == 1, "R11 one done", done_cnt, 1);
        chk(req_rises == 9, "R10 one request per burst", req_rises, 9);
        chk(mem_addr[6:0] == 0, "R4 block aligned after run", mem_addr, 0);
        chk(dev_addr == 32'h2000_0005 + 126*8, "R5 dev advanced", dev_addr, 32'h2000_0005 + 126*8);

        // aligned 256 bytes: two full bursts, slow grant and beats
        wr(2'd0, 32'h0000_8000);
        clr_counts();
        wr(2'd2, 32'd256);
        serve(4, 2, 0, 0);
        chk(req_rises == 2, "R3 two full bursts", req_rises, 2);
        chk(mem_addr == 32'h0000_8100, "R4 next block", mem_addr, 32'h0000_8100);

        // last double-word of a block with offset 6: bursts of 1 and 1
        wr(2'd0, 32'h0000_007E);
        clr_counts();
        wr(2'd2, 32'd5);
        @(negedge clk);
        chk(remain_dw == 2, "R2 offset folded into count", remain_dw, 2);
        serve(0, 0, 0, 0);
        chk(req_rises == 2, "R3 single-dw first burst", req_rises, 2);

        // R6 zero length
        clr_counts();
        wr(2'd2, 32'd0);
        serve(0, 0, 0, 0);
        chk(req_rises == 0, "R6 no request", req_rises, 0);
        chk(done_cnt == 1, "R6 done reported", done_cnt, 1);

        // R7 read-direction start
        clr_counts();
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd64;
        @(negedge clk);
        reg_we = 1'b0;
        chk(err_irq == 1'b1, "R7 err pulse", err_irq, 1);
        chk(busy == 1'b0, "R7 no transfer", busy, 0);
        @(negedge clk);
        chk(err_irq == 1'b0 && err_cnt == 1, "R7 single pulse", err_cnt, 1);

        // R8 writes during transfer ignored
        wr(2'd0, 32'h0000_4040);
        wr(2'd1, 32'h0000_0000);
        clr_counts();
        wr(2'd2, 32'd200);
        serve(1, 1, 0, 1);
        chk(done_cnt == 1 && busy == 0, "R8 no restart from busy write", busy, 0);
        chk(dev_addr == 32'd200, "R8 dev not reloaded", dev_addr, 200);

        // R9 stop while requesting
        clr_counts();
        wr(2'd2, 32'd64);
        serve(2, 0, 1, 0);
        chk(busy == 0 && done_cnt == 0, "R9 stop in request", done_cnt, 0);

        // R9 stop mid burst
        wr(2'd0, 32'h0000_0000);
        clr_counts();
        wr(2'd2, 32'd128);
        serve(0, 0, 2, 0);
        chk(busy == 0 && done_cnt == 0, "R9 stop mid burst", done_cnt, 0);
        chk(remain_dw == 15, "R5 count after one beat", remain_dw, 15);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule